// File: doc/BRIEF.md
# Two-Thread Back-End Entry Allocator

This block hands out back-end buffer entries to micro-ops coming from two hardware threads. Each thread presents the head micro-op of its front-end queue as a request. Every micro-op needs one reorder-buffer entry. A load also needs one load-buffer entry, and a store also needs one store-buffer entry. In each cycle the allocator grants at most one micro-op. With the grant it returns the entry indices taken from per-buffer free lists. A thread that cannot be served because of its own limits is shown as stalled. Retirement returns entries through one release port per buffer, tagged with the owning thread.

In two-thread mode every thread is capped at half of each buffer. This keeps either thread from starving the other. When both threads are eligible they are served in turn. A thread that is the only eligible requester is served every cycle. In single-thread mode one selected thread may fill every buffer completely. The other thread's requests are ignored.

Top module: `smt_alloc`

## Requirements
- R1: After reset every entry of the reorder (126), load (48) and store (24) buffers is free, both occupancy counts are zero, and no grant or stall is raised while no request is present.
- R2: A grant in cycle N returns, for each buffer, the lowest-numbered entry that is free in cycle N. An entry released in cycle N becomes grantable from cycle N+1.
- R3: In two-thread mode, when both threads are eligible in consecutive cycles, the granted thread (gnt_tid, 0 or 1) differs between those cycles. The first such contest after reset goes to thread 0.
- R4: In two-thread mode a thread never holds more than 63 reorder, 24 load or 12 store entries.
- R5: A requesting enabled thread that lacks a needed resource raises its own bit of stall (bit 0 = thread 0), is not granted, and does not block a grant to the other thread in the same cycle.
- R6: When only one thread is eligible it is granted in every cycle, with its two-thread caps still applied.
- R7: In single-thread mode (single_mode=1) the thread named by solo_tid may use every entry of every buffer. The other thread is never granted or stalled. Mode may only change while the thread being disabled holds no entries.
- R8: A micro-op is granted only when every resource it needs is available in the same cycle. A stalled micro-op consumes no entry of any buffer.
- R9: An allocation and a release for the same thread and buffer in the same cycle leave that thread's count unchanged. The count is still correct when it is sitting one below the cap.
- R10: gnt is raised only for a thread that is requesting and enabled, and gnt_tid names that thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_mode | input | 1 | 1 = single-thread mode, caps lifted |
| solo_tid | input | 1 | Thread enabled in single-thread mode |
| req_vld | input | 2 | Per-thread head micro-op valid |
| req_ld | input | 2 | Per-thread head micro-op needs a load entry |
| req_st | input | 2 | Per-thread head micro-op needs a store entry |
| rob_rel | input | 1 | Release one reorder entry |
| rob_rel_tid | input | 1 | Owner of the released reorder entry |
| rob_rel_idx | input | 7 | Index of the released reorder entry |
| ldb_rel | input | 1 | Release one load entry |
| ldb_rel_tid | input | 1 | Owner of the released load entry |
| ldb_rel_idx | input | 6 | Index of the released load entry |
| stb_rel | input | 1 | Release one store entry |
| stb_rel_tid | input | 1 | Owner of the released store entry |
| stb_rel_idx | input | 5 | Index of the released store entry |
| gnt | output | 1 | A micro-op is allocated this cycle |
| gnt_tid | output | 1 | Thread of the allocated micro-op |
| gnt_rob_idx | output | 7 | Allocated reorder entry |
| gnt_ldb_idx | output | 6 | Allocated load entry (valid for loads) |
| gnt_stb_idx | output | 5 | Allocated store entry (valid for stores) |
| stall | output | 2 | Per-thread stall on a missing resource |

## Verification
An allocation and a release can update the same thread's store count in the same cycle. The bench brings thread 0 to one store below its cap. It then asks for a store while retiring one of that thread's stores in the same cycle. The count is judged correct if exactly one more store is granted afterwards, reusing the freed lowest entry, and the next store request stalls while thread 1 is still granted.

// File: rtl/smt_alloc.sv
module smt_alloc #(
  parameter int ROB_N = 126,
  parameter int LDB_N = 48,
  parameter int STB_N = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     single_mode,
  input  logic                     solo_tid,
  input  logic [1:0]               req_vld,
  input  logic [1:0]               req_ld,
  input  logic [1:0]               req_st,
  input  logic                     rob_rel,
  input  logic                     rob_rel_tid,
  input  logic [$clog2(ROB_N)-1:0] rob_rel_idx,
  input  logic                     ldb_rel,
  input  logic                     ldb_rel_tid,
  input  logic [$clog2(LDB_N)-1:0] ldb_rel_idx,
  input  logic                     stb_rel,
  input  logic                     stb_rel_tid,
  input  logic [$clog2(STB_N)-1:0] stb_rel_idx,
  output logic                     gnt,
  output logic                     gnt_tid,
  output logic [$clog2(ROB_N)-1:0] gnt_rob_idx,
  output logic [$clog2(LDB_N)-1:0] gnt_ldb_idx,
  output logic [$clog2(STB_N)-1:0] gnt_stb_idx,
  output logic [1:0]               stall
);
  localparam int RW  = $clog2(ROB_N);
  localparam int LW  = $clog2(LDB_N);
  localparam int SW  = $clog2(STB_N);
  localparam int RCW = $clog2(ROB_N + 1);
  localparam int LCW = $clog2(LDB_N + 1);
  localparam int SCW = $clog2(STB_N + 1);
  localparam logic [RCW-1:0] ROB_CAP = RCW'(ROB_N / 2);
  localparam logic [LCW-1:0] LDB_CAP = LCW'(LDB_N / 2);
  localparam logic [SCW-1:0] STB_CAP = SCW'(STB_N / 2);

  logic [ROB_N-1:0] rob_free;
  logic [LDB_N-1:0] ldb_free;
  logic [STB_N-1:0] stb_free;
  logic [1:0][RCW-1:0] rob_cnt;
  logic [1:0][LCW-1:0] ldb_cnt;
  logic [1:0][SCW-1:0] stb_cnt;
  logic last_tid;

  wire [RCW-1:0] rob_lim = single_mode ? RCW'(ROB_N) : ROB_CAP;
  wire [LCW-1:0] ldb_lim = single_mode ? LCW'(LDB_N) : LDB_CAP;
  wire [SCW-1:0] stb_lim = single_mode ? SCW'(STB_N) : STB_CAP;

  wire rob_any = |rob_free;
  wire ldb_any = |ldb_free;
  wire stb_any = |stb_free;

  logic [1:0] enabled, fits, elig;

  for (genvar t = 0; t < 2; t++) begin : g_thr
    assign enabled[t] = !single_mode || (solo_tid == 1'(t));
    assign fits[t] = (rob_cnt[t] < rob_lim) && rob_any
                  && (!req_ld[t] || ((ldb_cnt[t] < ldb_lim) && ldb_any))
                  && (!req_st[t] || ((stb_cnt[t] < stb_lim) && stb_any));
    assign elig[t]  = req_vld[t] && enabled[t] && fits[t];
    assign stall[t] = req_vld[t] && enabled[t] && !fits[t];
  end

  wire sel = (elig == 2'b11) ? ~last_tid : elig[1];
  assign gnt     = |elig;
  assign gnt_tid = sel;

  wire rob_alloc = gnt;
  wire ldb_alloc = gnt && req_ld[sel];
  wire stb_alloc = gnt && req_st[sel];

  always_comb begin
    gnt_rob_idx = '0;
    for (int i = ROB_N - 1; i >= 0; i--)
      if (rob_free[i]) gnt_rob_idx = RW'(i);
  end

  always_comb begin
    gnt_ldb_idx = '0;
    for (int i = LDB_N - 1; i >= 0; i--)
      if (ldb_free[i]) gnt_ldb_idx = LW'(i);
  end

  always_comb begin
    gnt_stb_idx = '0;
    for (int i = STB_N - 1; i >= 0; i--)
      if (stb_free[i]) gnt_stb_idx = SW'(i);
  end

  wire [ROB_N-1:0] rob_take = rob_alloc ? ({{(ROB_N-1){1'b0}}, 1'b1} << gnt_rob_idx) : '0;
  wire [ROB_N-1:0] rob_give = rob_rel   ? ({{(ROB_N-1){1'b0}}, 1'b1} << rob_rel_idx) : '0;
  wire [LDB_N-1:0] ldb_take = ldb_alloc ? ({{(LDB_N-1){1'b0}}, 1'b1} << gnt_ldb_idx) : '0;
  wire [LDB_N-1:0] ldb_give = ldb_rel   ? ({{(LDB_N-1){1'b0}}, 1'b1} << ldb_rel_idx) : '0;
  wire [STB_N-1:0] stb_take = stb_alloc ? ({{(STB_N-1){1'b0}}, 1'b1} << gnt_stb_idx) : '0;
  wire [STB_N-1:0] stb_give = stb_rel   ? ({{(STB_N-1){1'b0}}, 1'b1} << stb_rel_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_free <= '1;
      ldb_free <= '1;
      stb_free <= '1;
      last_tid <= 1'b1;
    end else begin
      rob_free <= (rob_free & ~rob_take) | rob_give;
      ldb_free <= (ldb_free & ~ldb_take) | ldb_give;
      stb_free <= (stb_free & ~stb_take) | stb_give;
      if (gnt) last_tid <= sel;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_cnt
    wire rob_inc = rob_alloc && (sel == 1'(t));
    wire ldb_inc = ldb_alloc && (sel == 1'(t));
    wire stb_inc = stb_alloc && (sel == 1'(t));
    wire rob_dec = rob_rel && (rob_rel_tid == 1'(t));
    wire ldb_dec = ldb_rel && (ldb_rel_tid == 1'(t));
    wire stb_dec = stb_rel && (stb_rel_tid == 1'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rob_cnt[t] <= '0;
        ldb_cnt[t] <= '0;
        stb_cnt[t] <= '0;
      end else begin
        rob_cnt[t] <= rob_cnt[t] + RCW'(rob_inc) - RCW'(rob_dec);
        ldb_cnt[t] <= ldb_cnt[t] + LCW'(ldb_inc) - LCW'(ldb_dec);
        stb_cnt[t] <= stb_cnt[t] + SCW'(stb_inc) - SCW'(stb_dec);
      end
    end
  end
endmodule

// File: rtl/smt_alloc_chk.sv
module smt_alloc_chk #(
  parameter int ROB_N = 126,
  parameter int LDB_N = 48,
  parameter int STB_N = 24
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            single_mode,
  input logic                            solo_tid,
  input logic [1:0]                      req_vld,
  input logic                            gnt,
  input logic                            gnt_tid,
  input logic [1:0]                      stall,
  input logic [1:0][$clog2(ROB_N+1)-1:0] rob_cnt,
  input logic [1:0][$clog2(LDB_N+1)-1:0] ldb_cnt,
  input logic [1:0][$clog2(STB_N+1)-1:0] stb_cnt,
  input logic [ROB_N-1:0]                rob_free,
  input logic [LDB_N-1:0]                ldb_free,
  input logic [STB_N-1:0]                stb_free
);
  wire both_ok = gnt && (req_vld == 2'b11) && (stall == 2'b00) && !single_mode;

  a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    both_ok ##1 both_ok |-> gnt_tid != $past(gnt_tid));

  a_r4_caps: assert property (@(posedge clk) disable iff (!rst_n)
    !single_mode |-> (int'(rob_cnt[0]) <= ROB_N/2) && (int'(rob_cnt[1]) <= ROB_N/2)
                  && (int'(ldb_cnt[0]) <= LDB_N/2) && (int'(ldb_cnt[1]) <= LDB_N/2)
                  && (int'(stb_cnt[0]) <= STB_N/2) && (int'(stb_cnt[1]) <= STB_N/2));

  a_r5_stall0_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    stall[0] |-> !(gnt && !gnt_tid));

  a_r5_stall1_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    stall[1] |-> !(gnt && gnt_tid));

  a_r6_lone_served: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_mode && req_vld == 2'b01 && !stall[0]) |-> gnt && !gnt_tid);

  a_r7_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |-> !stall[~solo_tid] && !(gnt && gnt_tid != solo_tid));

  a_r7_switch_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (single_mode && !$past(single_mode)) |-> rob_cnt[~solo_tid] == '0);

  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rob_cnt[0]) + int'(rob_cnt[1]) + $countones(rob_free) == ROB_N)
    && (int'(ldb_cnt[0]) + int'(ldb_cnt[1]) + $countones(ldb_free) == LDB_N)
    && (int'(stb_cnt[0]) + int'(stb_cnt[1]) + $countones(stb_free) == STB_N));

  a_r10_grant_valid: assert property (@(posedge clk) disable iff (!rst_n)
    gnt |-> req_vld[gnt_tid]);
endmodule

bind smt_alloc smt_alloc_chk #(.ROB_N(ROB_N), .LDB_N(LDB_N), .STB_N(STB_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .single_mode(single_mode), .solo_tid(solo_tid),
  .req_vld(req_vld), .gnt(gnt), .gnt_tid(gnt_tid), .stall(stall),
  .rob_cnt(rob_cnt), .ldb_cnt(ldb_cnt), .stb_cnt(stb_cnt),
  .rob_free(rob_free), .ldb_free(ldb_free), .stb_free(stb_free)
);

// File: tb/smt_alloc_tb.sv
`timescale 1ns/1ps
module smt_alloc_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, single_mode, solo_tid;
  logic [1:0] req_vld, req_ld, req_st, stall;
  logic rob_rel, rob_rel_tid, ldb_rel, ldb_rel_tid, stb_rel, stb_rel_tid;
  logic [6:0] rob_rel_idx, gnt_rob_idx;
  logic [5:0] ldb_rel_idx, gnt_ldb_idx;
  logic [4:0] stb_rel_idx, gnt_stb_idx;
  logic gnt, gnt_tid;

  int checks = 0, errors = 0;
  bit finished = 0;

  smt_alloc u_dut (.*);

  // {req_vld, req_ld, req_st, gnt, tid, rob, ldb, stb, stall}
  localparam logic [27:0] VEC [7] = '{
    {2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 7'd0, 6'd0, 5'd0, 2'b00},
    {2'b11, 2'b01, 2'b10, 1'b1, 1'b0, 7'd0, 6'd0, 5'd0, 2'b00},
    {2'b11, 2'b01, 2'b10, 1'b1, 1'b1, 7'd1, 6'd1, 5'd0, 2'b00},
    {2'b10, 2'b00, 2'b00, 1'b1, 1'b1, 7'd2, 6'd1, 5'd1, 2'b00},
    {2'b10, 2'b00, 2'b00, 1'b1, 1'b1, 7'd3, 6'd1, 5'd1, 2'b00},
    {2'b11, 2'b00, 2'b11, 1'b1, 1'b0, 7'd4, 6'd1, 5'd1, 2'b00},
    {2'b01, 2'b00, 2'b00, 1'b1, 1'b0, 7'd5, 6'd1, 5'd2, 2'b00}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] v, logic [1:0] l, logic [1:0] s);
    req_vld = v; req_ld = l; req_st = s;
    #1;
  endtask

  task automatic do_reset(logic sm, logic st);
    rst_n = 0; single_mode = sm; solo_tid = st;
    req_vld = 0; req_ld = 0; req_st = 0;
    rob_rel = 0; rob_rel_tid = 0; rob_rel_idx = 0;
    ldb_rel = 0; ldb_rel_tid = 0; ldb_rel_idx = 0;
    stb_rel = 0; stb_rel_tid = 0; stb_rel_idx = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 R2 R3 R6 R10: vector walk from reset in two-thread mode
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) begin
      drive(VEC[i][27:26], VEC[i][25:24], VEC[i][23:22]);
      chk(i == 0 ? "R1/R10 reset idle" : (i == 3 || i == 4 || i == 6) ? "R6 lone thread" : "R2/R3 alternation",
          {10'd0, gnt, gnt_tid, gnt_rob_idx, gnt_ldb_idx, gnt_stb_idx, stall},
          {10'd0, VEC[i][21:0]});
      @(negedge clk);
    end

    // R4 R5 R8 R9: store cap of thread 0
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 11; i++) begin
      drive(2'b01, 2'b00, 2'b01);
      chk("R4 store under cap", {gnt, gnt_tid, gnt_stb_idx}, {1'b1, 1'b0, 5'(i)});
      @(negedge clk);
    end
    stb_rel = 1; stb_rel_tid = 0; stb_rel_idx = 0;
    drive(2'b01, 2'b00, 2'b01);
    chk("R9 alloc with release", {gnt, gnt_tid, gnt_stb_idx}, {1'b1, 1'b0, 5'd11});
    @(negedge clk);
    stb_rel = 0;
    drive(2'b01, 2'b00, 2'b01);
    chk("R9/R2 reuse freed entry", {gnt, gnt_tid, gnt_stb_idx, stall}, {1'b1, 1'b0, 5'd0, 2'b00});
    @(negedge clk);
    drive(2'b11, 2'b00, 2'b11);
    chk("R5/R4 thread0 capped, thread1 served", {gnt, gnt_tid, gnt_stb_idx, stall}, {1'b1, 1'b1, 5'd12, 2'b01});
    chk("R8 stalled uop takes no reorder entry", {25'd0, gnt_rob_idx}, {25'd0, 7'd13});
    @(negedge clk);
    drive(2'b01, 2'b00, 2'b01);
    chk("R4 cap holds alone", {gnt, stall}, {1'b0, 2'b01});
    @(negedge clk);
    drive(2'b01, 2'b00, 2'b00);
    chk("R8 non-store uop proceeds", {gnt, gnt_tid, gnt_rob_idx, stall}, {1'b1, 1'b0, 7'd14, 2'b00});
    @(negedge clk);

    // R7: single-thread mode, thread 1 fills the store buffer
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 24; i++) begin
      drive(2'b11, 2'b00, 2'b11);
      chk("R7 caps lifted, thread0 ignored", {gnt, gnt_tid, gnt_stb_idx, stall}, {1'b1, 1'b1, 5'(i), 2'b00});
      @(negedge clk);
    end
    drive(2'b11, 2'b00, 2'b11);
    chk("R7 buffer full stalls solo thread only", {gnt, stall}, {1'b0, 2'b10});
    @(negedge clk);
    drive(2'b00, 2'b00, 2'b00);
    chk("R1/R10 idle no grant", {gnt, stall}, {1'b0, 2'b00});

    finish_run();
  end
endmodule